// File: doc/BRIEF.md
# Indexed Configuration Register Slave on SMBus

This block is a two-wire SMBus target that owns a 32-byte configuration register file. A host reaches the file through indexed transfers. Each transfer names a start offset and then moves a counted block of bytes. Successive bytes land at, or come from, consecutive offsets, and the offset wraps from 31 back to 0. The register contents are exported as one flat vector, so surrounding logic can use them directly.

Two bytes are partly or wholly fixed. A revision/vendor identifier occupies one byte. The low three bits of a status byte mirror the latched frequency-select strap inputs. Host writes to these bits are dropped.

The block oversamples SCL and SDA with the system clock and never stretches the clock. It pulls SDA low only through an open-drain enable. A block read first returns a count byte, which is held in a separate register, and then returns data. The host ends a read with a NACK followed by STOP. It may also stop early.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset SDA is released, every writable register byte reads 00h, and the read count register holds 08h.
- R2: The 8-bit address bytes D2h (write) and D3h (read) are acknowledged. Any other address byte gets a NACK, and every following byte is ignored until the next START.
- R3: A write transfer is D2h, offset, count N, then N data bytes. The slave ACKs each of these bytes. Data byte k is stored at offset+k.
- R4: The offset is taken modulo 32 and steps by one after each data byte, wrapping from 31 to 0, in both writes and reads.
- R5: Byte 7 always reads 05h. Bits 2:0 of byte 6 always show the strap inputs and follow them when they change. Writes leave these bits unchanged, while bits 7:3 of byte 6 are writable.
- R6: A count byte of 00h gets a NACK, and the transfer is dropped. Later data bytes get a NACK and are not stored.
- R7: Data bytes beyond the count N of a write get a NACK and are not stored.
- R8: After D3h the slave sends the count register and then data starting at the stored offset. It keeps sending while the master ACKs and releases SDA after a NACK.
- R9: The count register is loaded with the count byte of every write whose count is non-zero.
- R10: A STOP at any point releases SDA and returns the block to idle. A START at any point abandons the current transfer and begins a new address phase.
- R11: Register byte i is exported on cfg_o bits 8i+7 to 8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | STRAP_W (3) | Latched frequency-select strap value |
| cfg_o | output | NBYTES*8 (256) | Exported register contents, byte i at bits 8i+7:8i |

## Verification
A corrupted offset pointer appears in the first data byte after the next count byte, either on cfg_o for a write or on SDA for a read. A stuck sequencer state shows up within one byte time as a missing or unexpected ACK. A lost abort leaves SDA held low after a STOP, which the first sample after that STOP reveals. A wrong count register appears in the first byte of the next block read.

// File: rtl/smb_cfg_pkg.sv
// Shared types for the SMBus indexed register slave.
// Assumes: byte-wide bus transfers.
package smb_cfg_pkg;
    localparam int unsigned BYTE_W = 8;

    // Sequencer states of the byte engine
    typedef enum logic [2:0] {
        S_IDLE,   // waiting for START
        S_ADDR,   // receiving address byte
        S_OFFS,   // receiving register offset
        S_CNT,    // receiving byte count
        S_WDAT,   // receiving write data
        S_ACK,    // slave ACK bit in progress
        S_TX,     // slave shifting a byte out
        S_TXACK   // master ACK/NACK bit in progress
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and detects
// SCL edges and START/STOP conditions.
// Assumes: system clock is many times faster than SCL; both lines idle high.
module smb_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_ff;
    logic [DEPTH-1:0] sda_ff;
    logic scl_s, scl_q, sda_s, sda_q;

    // Synchroniser chains plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[DEPTH-2:0], scl_i};
            sda_ff <= {sda_ff[DEPTH-2:0], sda_i};
        end
    end

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign scl_q = scl_ff[SYNC_STAGES];
    assign sda_s = sda_ff[SYNC_STAGES-1];
    assign sda_q = sda_ff[SYNC_STAGES];

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~scl_q;
    assign scl_fall_o = ~scl_s & scl_q;
    assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_cfg_regs.sv
// Configuration register file: NBYTES bytes, one identifier byte that is
// fully read-only, one status byte whose low bits mirror the straps, and a
// separate read-count register.
// Assumes: STRAP_W <= 8; at most one write per cycle.
module smb_cfg_regs #(
    parameter int unsigned NBYTES    = 32,
    parameter int unsigned ID_IDX    = 7,
    parameter logic [7:0]  ID_VAL    = 8'h05,
    parameter int unsigned STRAP_IDX = 6,
    parameter int unsigned STRAP_W   = 3,
    parameter logic [7:0]  CNT_RST   = 8'h08,
    localparam int unsigned IDX_W    = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [7:0]           wr_data_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [7:0]           rd_data_o,
    input  logic [STRAP_W-1:0]   strap_i,
    input  logic                 cnt_wr_i,
    input  logic [7:0]           cnt_data_i,
    output logic [7:0]           cnt_o,
    output logic [NBYTES*8-1:0]  cfg_o
);
    localparam logic [7:0] STRAP_MASK = 8'((1 << STRAP_W) - 1);

    logic [7:0] view_w [NBYTES];
    logic [7:0] strap_byte;

    assign strap_byte = 8'(strap_i);

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        localparam logic [7:0] RO_MASK = (gi == ID_IDX)    ? 8'hFF :
                                         (gi == STRAP_IDX) ? STRAP_MASK : 8'h00;
        localparam bit IS_ID = (gi == ID_IDX);
        logic [7:0] store_q;
        logic [7:0] fixed_w;

        assign fixed_w = IS_ID ? ID_VAL : strap_byte;

        // Byte storage; read-only bits are never loaded
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q <= 8'h00;
            end else if (wr_en_i && wr_idx_i == IDX_W'(gi)) begin
                store_q <= wr_data_i & ~RO_MASK;
            end
        end

        assign view_w[gi]           = (store_q & ~RO_MASK) | (fixed_w & RO_MASK);
        assign cfg_o[gi*8 +: 8]     = view_w[gi];
    end

    assign rd_data_o = view_w[rd_idx_i];

    // Read-back count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= CNT_RST;
        end else if (cnt_wr_i) begin
            cnt_o <= cnt_data_i;
        end
    end
endmodule

// File: rtl/smb_cfg_fsm.sv
// Byte-level sequencer: shifts address, offset, count and data bytes in on
// SCL rising edges, drives ACK and read data after SCL falling edges, keeps
// the auto-incrementing offset pointer, and aborts on START or STOP.
// Assumes: inputs come from smb_line_sync; no clock stretching.
module smb_cfg_fsm
    import smb_cfg_pkg::*;
#(
    parameter int unsigned NBYTES = 32,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    localparam int unsigned IDX_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [7:0]        wr_data_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [7:0]        rd_data_i,
    output logic              cnt_wr_o,
    output logic [7:0]        cnt_data_o,
    input  logic [7:0]        cnt_i
);
    smb_state_e       state_q, nxt_q;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       rx_sh_q, tx_sh_q, wr_left_q;
    logic [IDX_W-1:0] ptr_q;
    logic             first_tx_q, acked_q;
    logic [7:0]       tx_next;

    // Next byte to transmit: the count first, then register data
    always_comb tx_next = first_tx_q ? cnt_i : rd_data_i;

    assign rd_idx_o = ptr_q;

    // Main sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            nxt_q      <= S_IDLE;
            bit_cnt_q  <= 4'd0;
            rx_sh_q    <= 8'h00;
            tx_sh_q    <= 8'h00;
            wr_left_q  <= 8'h00;
            ptr_q      <= '0;
            first_tx_q <= 1'b0;
            acked_q    <= 1'b0;
            sda_oe_o   <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_idx_o   <= '0;
            wr_data_o  <= 8'h00;
            cnt_wr_o   <= 1'b0;
            cnt_data_o <= 8'h00;
        end else begin
            wr_en_o  <= 1'b0;
            cnt_wr_o <= 1'b0;
            if (stop_i) begin
                state_q  <= S_IDLE;
                sda_oe_o <= 1'b0;
            end else if (start_i) begin
                state_q   <= S_ADDR;
                bit_cnt_q <= 4'd0;
                sda_oe_o  <= 1'b0;
            end else begin
                case (state_q)
                    S_ADDR, S_OFFS, S_CNT, S_WDAT: begin
                        if (scl_rise_i) begin
                            rx_sh_q   <= {rx_sh_q[6:0], sda_i};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
                            bit_cnt_q <= 4'd0;
                            state_q   <= S_ACK;
                            case (state_q)
                                S_ADDR: begin
                                    if (rx_sh_q[7:1] == DEV_ADDR) begin
                                        sda_oe_o   <= 1'b1;
                                        nxt_q      <= rx_sh_q[0] ? S_TX : S_OFFS;
                                        first_tx_q <= 1'b1;
                                    end else begin
                                        state_q <= S_IDLE;
                                    end
                                end
                                S_OFFS: begin
                                    sda_oe_o <= 1'b1;
                                    ptr_q    <= rx_sh_q[IDX_W-1:0];
                                    nxt_q    <= S_CNT;
                                end
                                S_CNT: begin
                                    if (rx_sh_q != 8'h00) begin
                                        sda_oe_o   <= 1'b1;
                                        wr_left_q  <= rx_sh_q;
                                        cnt_wr_o   <= 1'b1;
                                        cnt_data_o <= rx_sh_q;
                                        nxt_q      <= S_WDAT;
                                    end else begin
                                        state_q <= S_IDLE;
                                    end
                                end
                                default: begin
                                    if (wr_left_q != 8'h00) begin
                                        sda_oe_o  <= 1'b1;
                                        wr_en_o   <= 1'b1;
                                        wr_idx_o  <= ptr_q;
                                        wr_data_o <= rx_sh_q;
                                        ptr_q     <= ptr_q + IDX_W'(1);
                                        wr_left_q <= wr_left_q - 8'd1;
                                        nxt_q     <= S_WDAT;
                                    end else begin
                                        state_q <= S_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    S_ACK: begin
                        if (scl_fall_i) begin
                            if (nxt_q == S_TX) begin
                                tx_sh_q    <= tx_next;
                                sda_oe_o   <= ~tx_next[7];
                                first_tx_q <= 1'b0;
                                if (!first_tx_q) ptr_q <= ptr_q + IDX_W'(1);
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                            bit_cnt_q <= 4'd0;
                            state_q   <= nxt_q;
                        end
                    end
                    S_TX: begin
                        if (scl_fall_i) begin
                            if (bit_cnt_q == 4'd7) begin
                                sda_oe_o <= 1'b0;
                                state_q  <= S_TXACK;
                            end else begin
                                tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
                                sda_oe_o  <= ~tx_sh_q[6];
                                bit_cnt_q <= bit_cnt_q + 4'd1;
                            end
                        end
                    end
                    S_TXACK: begin
                        if (scl_rise_i) begin
                            acked_q <= ~sda_i;
                        end else if (scl_fall_i) begin
                            if (acked_q) begin
                                tx_sh_q   <= tx_next;
                                sda_oe_o  <= ~tx_next[7];
                                ptr_q     <= ptr_q + IDX_W'(1);
                                bit_cnt_q <= 4'd0;
                                state_q   <= S_TX;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    S_IDLE: ;
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    // R10: the line is never held while the engine is idle
    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_IDLE |-> !sda_oe_o);

    // R10: a STOP releases the bus and idles the engine
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == S_IDLE && !sda_oe_o));

    // R2: a foreign address is not acknowledged
    p_foreign_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && scl_fall_i && bit_cnt_q == 4'd8 &&
         rx_sh_q[7:1] != DEV_ADDR) |=> (!sda_oe_o && state_q == S_IDLE));

    // R6: a zero count is refused and no count is recorded
    p_zero_cnt_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CNT && scl_fall_i && bit_cnt_q == 4'd8 && rx_sh_q == 8'h00)
        |=> (!sda_oe_o && !cnt_wr_o && state_q == S_IDLE));

    // R7: data past the count is refused and not written
    p_over_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WDAT && scl_fall_i && bit_cnt_q == 4'd8 && wr_left_q == 8'h00)
        |=> (!sda_oe_o && !wr_en_o));
endmodule

// File: rtl/smb_cfg_slave.sv
// Top level of the SMBus indexed register slave: line synchroniser,
// byte sequencer and register file.
// Assumes: clk oversamples SCL by at least 8x; rst_n is synchronous.
module smb_cfg_slave #(
    parameter int unsigned NBYTES    = 32,
    parameter logic [6:0]  DEV_ADDR  = 7'h69,
    parameter int unsigned ID_IDX    = 7,
    parameter logic [7:0]  ID_VAL    = 8'h05,
    parameter int unsigned STRAP_IDX = 6,
    parameter int unsigned STRAP_W   = 3,
    parameter logic [7:0]  CNT_RST   = 8'h08
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic [STRAP_W-1:0]   strap_i,
    output logic [NBYTES*8-1:0]  cfg_o
);
    localparam int unsigned IDX_W = $clog2(NBYTES);

    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en, cnt_wr;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data, cnt_data, cnt_q;

    smb_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    smb_cfg_fsm #(.NBYTES(NBYTES), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .rd_idx_o   (rd_idx),
        .rd_data_i  (rd_data),
        .cnt_wr_o   (cnt_wr),
        .cnt_data_o (cnt_data),
        .cnt_i      (cnt_q)
    );

    smb_cfg_regs #(
        .NBYTES(NBYTES), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL),
        .STRAP_IDX(STRAP_IDX), .STRAP_W(STRAP_W), .CNT_RST(CNT_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (rd_data),
        .strap_i    (strap_i),
        .cnt_wr_i   (cnt_wr),
        .cnt_data_i (cnt_data),
        .cnt_o      (cnt_q),
        .cfg_o      (cfg_o)
    );
endmodule

// File: tb/test_smb_cfg_slave.sv
// Scoreboard bench: bus tasks push expected ACK bits and read bytes into a
// queue; a monitor pops and compares each observed item.
module test_smb_cfg_slave;
    localparam int Q = 10;  // system clocks per quarter SCL period

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_oe;
    logic         sda_line;
    logic [2:0]   strap = 3'b101;
    logic [255:0] cfg;

    int n_vec = 0;
    int n_bad = 0;
    int exp_val[$];
    string exp_tag[$];
    int obs_val;
    event obs_ev;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    assign sda_line = sda_m & ~sda_oe;

    smb_cfg_slave i_smb_cfg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .cfg_o    (cfg)
    );

    function automatic int cfgb(int i);  // R11: byte i at bits 8i+7:8i
        return int'(cfg[i*8 +: 8]);
    endfunction

    task automatic chk(int act, int exp, string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic observe(int v);
        obs_val = v;
        ->obs_ev;
        @(negedge clk);
    endtask

    // Monitor: pops one expectation per observed bus item
    initial begin
        forever begin
            @(obs_ev);
            n_vec++;
            if (exp_val.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected item: actual %0h expected none", obs_val);
            end else begin
                int e;
                string t;
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                if (obs_val != e) begin
                    n_bad++;
                    $display("FAIL %s: actual %0h expected %0h", t, obs_val, e);
                end
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic clk_bit(bit b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait();
        scl_m = 1'b0; qwait();
    endtask

    // Driver: master sends a byte, expectation is the slave's ACK (1) or NACK (0)
    task automatic tx(int b, int exp_ack, string tag);
        exp_val.push_back(exp_ack);
        exp_tag.push_back(tag);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        begin
            int a;
            a = sda_line ? 0 : 1;
            scl_m = 1'b0;
            observe(a);
        end
        qwait();
    endtask

    // Driver: master reads a byte, then ACKs (1) or NACKs (0)
    task automatic rx(int exp, bit mack, string tag);
        int v;
        exp_val.push_back(exp);
        exp_tag.push_back(tag);
        v = 0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qwait();
            scl_m = 1'b1; qwait();
            v = (v << 1) | int'(sda_line);
            scl_m = 1'b0;
        end
        observe(v);
        qwait();
        clk_bit(!mack);
        sda_m = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state, R5 fixed bytes, R11 export layout
        chk(int'(sda_oe), 0, "R1 sda released");
        chk(cfgb(0), 8'h00, "R1 byte0");
        chk(cfgb(31), 8'h00, "R1 byte31");
        chk(cfgb(7), 8'h05, "R5 id byte");
        chk(cfgb(6), 8'h05, "R5 strap bits");

        // R8/R9: read at reset returns count 08h then data from offset 7
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h07, 1, "R8 offset");
        bus_start();
        tx(8'hD3, 1, "R2 read addr");
        rx(8'h08, 1, "R9 reset count");
        rx(8'h05, 1, "R8 data at offset");
        rx(8'h00, 0, "R8 next data");
        bus_stop();
        chk(int'(sda_oe), 0, "R8 released after nack");

        // R3 block write of two bytes at offset 3
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h03, 1, "R3 offset");
        tx(8'h02, 1, "R3 count");
        tx(8'hA5, 1, "R3 data0");
        tx(8'h3C, 1, "R3 data1");
        bus_stop();
        chk(cfgb(3), 8'hA5, "R3 byte3 R11");
        chk(cfgb(4), 8'h3C, "R3 byte4 R11");

        // R8/R9: read back, count now 02h
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h03, 1, "R8 offset");
        bus_start();
        tx(8'hD3, 1, "R2 read addr");
        rx(8'h02, 1, "R9 loaded count");
        rx(8'hA5, 1, "R8 data0");
        rx(8'h3C, 0, "R8 data1");
        bus_stop();

        // R4 wrap on write and read
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h1F, 1, "R4 offset");
        tx(8'h02, 1, "R4 count");
        tx(8'h11, 1, "R4 data31");
        tx(8'h22, 1, "R4 data0");
        bus_stop();
        chk(cfgb(31), 8'h11, "R4 byte31");
        chk(cfgb(0), 8'h22, "R4 wrapped byte0");
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h1F, 1, "R4 offset");
        bus_start();
        tx(8'hD3, 1, "R2 read addr");
        rx(8'h02, 1, "R9 count");
        rx(8'h11, 1, "R4 read byte31");
        rx(8'h22, 0, "R4 read wrapped byte0");
        bus_stop();

        // R5 read-only bits
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h06, 1, "R5 offset");
        tx(8'h02, 1, "R5 count");
        tx(8'hFF, 1, "R5 data6");
        tx(8'hFF, 1, "R5 data7");
        bus_stop();
        chk(cfgb(6), 8'hFD, "R5 byte6 after write");
        chk(cfgb(7), 8'h05, "R5 byte7 after write");
        strap = 3'b010;
        repeat (3) @(negedge clk);
        chk(cfgb(6), 8'hFA, "R5 strap follows");

        // R7 data beyond count
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h0A, 1, "R7 offset");
        tx(8'h01, 1, "R7 count");
        tx(8'h77, 1, "R7 data0");
        tx(8'h88, 0, "R7 extra nack");
        bus_stop();
        chk(cfgb(10), 8'h77, "R7 byte10");
        chk(cfgb(11), 8'h00, "R7 byte11 untouched");

        // R6 zero count
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h0C, 1, "R6 offset");
        tx(8'h00, 0, "R6 zero count nack");
        tx(8'h99, 0, "R6 data nack");
        bus_stop();
        chk(cfgb(12), 8'h00, "R6 byte12 untouched");

        // R2 foreign address ignored
        bus_start();
        tx(8'hA0, 0, "R2 foreign nack");
        tx(8'h0C, 0, "R2 ignored byte");
        bus_stop();
        chk(cfgb(12), 8'h00, "R2 byte12 untouched");

        // R10 early stop after count; R9 count not changed by zero count
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h0A, 1, "R10 offset");
        bus_start();
        tx(8'hD3, 1, "R2 read addr");
        rx(8'h01, 0, "R9 count kept");
        bus_stop();
        chk(int'(sda_oe), 0, "R10 released after early stop");

        // R10 START mid-byte aborts and restarts
        bus_start();
        tx(8'hD2, 1, "R2 write addr");
        tx(8'h0D, 1, "R10 offset");
        for (int i = 0; i < 4; i++) clk_bit(1'b0);
        bus_start();
        tx(8'hD2, 1, "R10 restart addr");
        tx(8'h0E, 1, "R10 offset");
        tx(8'h01, 1, "R10 count");
        tx(8'h5A, 1, "R10 data");
        bus_stop();
        chk(cfgb(14), 8'h5A, "R10 byte14");
        chk(cfgb(13), 8'h00, "R10 byte13 untouched");

        repeat (4) @(negedge clk);
        chk(exp_val.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule